// File: doc/BRIEF.md
# Password-Protected Watchdog Timer

This block is a countdown watchdog on a small register bus. Software configures it through one 32-bit control register. A write to that register only takes effect after an unlock handshake: first a write that carries an opening key, then a write that carries a commit key together with the new settings. A stray write, a wrong key, or a write to another address between the two steps cancels the handshake and leaves the settings as they were.

Once enabled, the block divides the input clock by a selectable ratio and counts down from a 16-bit reload value, one step per divided tick. It raises a sticky pre-warning flag when the remaining count drops to a chosen fraction of the reload value. When the count reaches zero it raises a sticky expiry flag and sends a one-cycle reset request. Software services the watchdog by repeating the unlock handshake, which reloads the counter. A read-only status register shows the live count and the flags.

Top module: `guard_wdt`

## Requirements
- R1: After reset the status word (address 0x8) and the control readback (address 0x0) both read zero, and `prewarn_o`, `expired_o` and `reset_req_o` are low.
- R2: A control write (address 0x0) with key byte 0xBE in bits 23:16 arms the unlock. The next control write with key byte 0xDC loads enable (bit 31), pre-warning select (bits 27:26), divider select (bits 25:24) and reload (bits 15:0) on that clock edge.
- R3: A control write with the wrong key for the current step, or any write to another address while armed, returns the unlock to idle without changing the settings. A commit key written while idle is rejected.
- R4: A commit write with enable and every field at zero stops the watchdog, and the status word then reads zero.
- R5: An accepted commit loads the counter with the new reload value, clears both flags and restarts the clock divider. With divide-by-1 the first decrement happens on the edge after the commit.
- R6: Divider select codes 0, 1, 2 and 3 give one tick every 1, 64, 4096 and 262144 clocks.
- R7: While enabled the count drops by one per tick. While disabled it holds its value.
- R8: The pre-warning flag sets when a tick leaves the count at or below reload shifted right by (select+1), that is 1/2, 1/4, 1/8 or 1/16 for codes 0 to 3. It stays set until the next accepted commit.
- R9: The tick that takes the count to zero (or a tick while the count is zero) sets the sticky expiry flag and holds the count at 0. `reset_req_o` is high for exactly the one cycle after that edge.
- R10: The status word at 0x8 holds the count in bits 15:0, pre-warning in bit 16, expiry in bit 17 and enable in bit 31, with the other bits zero. Writes to 0x8 change nothing.
- R11: Reading 0x0 returns the loaded enable, pre-warning select, divider select and reload in their control bit positions, with the key field and bits 30:28 reading zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Register byte address |
| bus_we | input | 1 | Write strobe, one write per asserted cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| prewarn_o | output | 1 | Sticky pre-warning flag |
| expired_o | output | 1 | Sticky expiry flag |
| reset_req_o | output | 1 | One-cycle reset request at expiry |

## Verification
A fault in the unlock state machine appears on the first commit that follows. The control readback and the status count either fail to reload or reload when they should not, and both can be read in the cycle after the write. Divider or counter faults shift the count seen at a fixed number of clocks after a commit, so the vectors read the status at exact cycle offsets where an off-by-one in either register chain changes the value. Flag faults appear as wrong bits 16 and 17 at those same offsets, and the expiry pulse is sampled in the cycle before, during and after its edge.

// File: rtl/guard_wdt_pkg.sv
package guard_wdt_pkg;

    localparam int WORD_W  = 32;
    localparam int CNT_W   = 16;
    localparam int KEY_W   = 8;
    localparam int SEL_W   = 2;
    localparam int DIV_STEP = 6;
    localparam int PRE_W   = DIV_STEP * ((1 << SEL_W) - 1);

    localparam int EN_BIT     = 31;
    localparam int WARN_LSB   = 26;
    localparam int DIV_LSB    = 24;
    localparam int KEY_LSB    = 16;
    localparam int RELOAD_LSB = 0;

    localparam int ST_WARN_BIT = 16;
    localparam int ST_EXP_BIT  = 17;
    localparam int ST_EN_BIT   = 31;

    localparam logic [KEY_W-1:0] KEY_OPEN   = 8'hBE;
    localparam logic [KEY_W-1:0] KEY_COMMIT = 8'hDC;

    typedef struct packed {
        logic             en;
        logic [SEL_W-1:0] warn_sel;
        logic [SEL_W-1:0] div_sel;
        logic [CNT_W-1:0] reload;
    } wdt_cfg_t;

    typedef enum logic {
        UNL_IDLE  = 1'b0,
        UNL_ARMED = 1'b1
    } unl_state_t;

endpackage

// File: rtl/guard_wdt_unlock.sv
module guard_wdt_unlock
    import guard_wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_wr_i,
    input  logic             other_wr_i,
    input  logic [KEY_W-1:0] key_i,
    output logic             commit_o
);

    typedef struct packed {
        unl_state_t st;
    } unl_regs_t;

    unl_regs_t regs_d, regs_q;

    always_comb begin
        regs_d   = regs_q;
        commit_o = 1'b0;
        if (ctrl_wr_i) begin
            case (regs_q.st)
                UNL_IDLE: begin
                    regs_d.st = (key_i == KEY_OPEN) ? UNL_ARMED : UNL_IDLE;
                end
                UNL_ARMED: begin
                    regs_d.st = UNL_IDLE;
                    commit_o  = (key_i == KEY_COMMIT);
                end
                default: regs_d.st = UNL_IDLE;
            endcase
        end else if (other_wr_i) begin
            regs_d.st = UNL_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '{st: UNL_IDLE};
        else        regs_q <= regs_d;
    end

    // R2: the opening key from idle arms the handshake
    p_open_arms_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr_i && key_i == KEY_OPEN && regs_q.st == UNL_IDLE) |=> regs_q.st == UNL_ARMED);

    // R3: a write elsewhere cancels the handshake
    p_stray_write_disarms_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (other_wr_i && !ctrl_wr_i) |=> regs_q.st == UNL_IDLE);

    // R3: a commit uses up the handshake, so two commits never follow each other
    p_commit_consumes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |=> (regs_q.st == UNL_IDLE && !commit_o));

endmodule

// File: rtl/guard_wdt_prescale.sv
module guard_wdt_prescale
    import guard_wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             restart_i,
    input  logic [SEL_W-1:0] div_sel_i,
    output logic             tick_o
);

    typedef struct packed {
        logic [PRE_W-1:0] div_cnt;
    } pre_regs_t;

    pre_regs_t        regs_d, regs_q;
    logic [PRE_W-1:0] mask;

    always_comb begin
        // code k divides by 2**(k*DIV_STEP); the top code wraps to all ones
        mask   = (PRE_W'(1) << (div_sel_i * DIV_STEP)) - PRE_W'(1);
        tick_o = run_i && !restart_i && ((regs_q.div_cnt & mask) == mask);
        regs_d = regs_q;
        if (restart_i || !run_i) regs_d.div_cnt = '0;
        else                     regs_d.div_cnt = regs_q.div_cnt + PRE_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '{div_cnt: '0};
        else        regs_q <= regs_d;
    end

    // R5: after a restart the divider only ticks at once for divide-by-1
    p_restart_quiets_r5: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (!tick_o || div_sel_i == '0));

    // R6: ratios above one never tick on two cycles in a row
    p_tick_spacing_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && div_sel_i != '0) |=> !tick_o);

endmodule

// File: rtl/guard_wdt_counter.sv
module guard_wdt_counter
    import guard_wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] reload_i,
    input  logic [SEL_W-1:0] warn_sel_i,
    input  logic             run_i,
    input  logic             tick_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             warn_o,
    output logic             expired_o,
    output logic             bite_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             warn;
        logic             expired;
        logic             bite;
    } cnt_regs_t;

    cnt_regs_t        regs_d, regs_q;
    logic [CNT_W-1:0] warn_level;
    logic [CNT_W-1:0] cnt_next;

    always_comb begin
        warn_level = reload_i >> ({1'b0, warn_sel_i} + 3'd1);
        cnt_next   = (regs_q.cnt <= CNT_W'(1)) ? '0 : regs_q.cnt - CNT_W'(1);
        regs_d      = regs_q;
        regs_d.bite = 1'b0;
        if (load_i) begin
            regs_d.cnt     = reload_i;
            regs_d.warn    = 1'b0;
            regs_d.expired = 1'b0;
        end else if (run_i && tick_i && !regs_q.expired) begin
            regs_d.cnt  = cnt_next;
            regs_d.warn = regs_q.warn || (cnt_next <= warn_level);
            if (regs_q.cnt <= CNT_W'(1)) begin
                regs_d.expired = 1'b1;
                regs_d.bite    = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '{cnt: '0, warn: 1'b0, expired: 1'b0, bite: 1'b0};
        else        regs_q <= regs_d;
    end

    assign cnt_o     = regs_q.cnt;
    assign warn_o    = regs_q.warn;
    assign expired_o = regs_q.expired;
    assign bite_o    = regs_q.bite;

    // R9: an expired watchdog shows a zero count
    p_expired_pins_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        expired_o |-> cnt_o == '0);

    // R9: the reset request lasts one cycle
    p_bite_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bite_o |=> !bite_o);

    // R7: a tick removes exactly one from the count
    p_step_by_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && run_i && tick_i && !expired_o && cnt_o > CNT_W'(1))
            |=> cnt_o == $past(cnt_o) - CNT_W'(1));

    // R7: a stopped watchdog keeps its count
    p_hold_when_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !run_i) |=> $stable(cnt_o));

    // R8: pre-warning stays until the next reload
    p_warn_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (warn_o && !load_i) |=> warn_o);

endmodule

// File: rtl/guard_wdt.sv
module guard_wdt
    import guard_wdt_pkg::*;
#(
    parameter int                ADDR_W    = 4,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(0),
    parameter logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(8)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              prewarn_o,
    output logic              expired_o,
    output logic              reset_req_o
);

    typedef struct packed {
        wdt_cfg_t cfg;
    } top_regs_t;

    top_regs_t        regs_d, regs_q;
    logic             ctrl_wr;
    logic             other_wr;
    logic             commit;
    logic             tick;
    logic [CNT_W-1:0] cnt;
    logic             warn;
    logic             expired;
    logic             bite;
    logic             unused_wdata_bits;

    assign ctrl_wr  = bus_we && (bus_addr == CTRL_ADDR);
    assign other_wr = bus_we && (bus_addr != CTRL_ADDR);
    assign unused_wdata_bits = ^bus_wdata[EN_BIT-1:WARN_LSB+SEL_W];

    guard_wdt_unlock u_unlock (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr_i  (ctrl_wr),
        .other_wr_i (other_wr),
        .key_i      (bus_wdata[KEY_LSB +: KEY_W]),
        .commit_o   (commit)
    );

    always_comb begin
        regs_d = regs_q;
        if (commit) begin
            regs_d.cfg.en       = bus_wdata[EN_BIT];
            regs_d.cfg.warn_sel = bus_wdata[WARN_LSB +: SEL_W];
            regs_d.cfg.div_sel  = bus_wdata[DIV_LSB +: SEL_W];
            regs_d.cfg.reload   = bus_wdata[RELOAD_LSB +: CNT_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    guard_wdt_prescale u_prescale (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (regs_q.cfg.en),
        .restart_i (commit),
        .div_sel_i (regs_q.cfg.div_sel),
        .tick_o    (tick)
    );

    guard_wdt_counter u_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (commit),
        .reload_i   (regs_d.cfg.reload),
        .warn_sel_i (regs_d.cfg.warn_sel),
        .run_i      (regs_q.cfg.en),
        .tick_i     (tick),
        .cnt_o      (cnt),
        .warn_o     (warn),
        .expired_o  (expired),
        .bite_o     (bite)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == CTRL_ADDR) begin
            bus_rdata[EN_BIT]                  = regs_q.cfg.en;
            bus_rdata[WARN_LSB +: SEL_W]       = regs_q.cfg.warn_sel;
            bus_rdata[DIV_LSB +: SEL_W]        = regs_q.cfg.div_sel;
            bus_rdata[RELOAD_LSB +: CNT_W]     = regs_q.cfg.reload;
        end else if (bus_addr == STAT_ADDR) begin
            bus_rdata[ST_EN_BIT]               = regs_q.cfg.en;
            bus_rdata[ST_EXP_BIT]              = expired;
            bus_rdata[ST_WARN_BIT]             = warn;
            bus_rdata[CNT_W-1:0]               = cnt;
        end
    end

    assign prewarn_o   = warn;
    assign expired_o   = expired;
    assign reset_req_o = bite;

    // R2: settings change only after a commit-key control write
    p_cfg_needs_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(regs_q.cfg) |-> $past(bus_we && bus_addr == CTRL_ADDR
                                       && bus_wdata[KEY_LSB +: KEY_W] == KEY_COMMIT));

    // R10: a status-register write leaves the settings alone
    p_status_write_inert_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == STAT_ADDR) |=> $stable(regs_q.cfg));

endmodule

// File: tb/guard_wdt_tb.sv
module guard_wdt_tb_top;

    typedef struct packed {
        logic [31:0] open_word;
        logic [31:0] cfg_word;
        logic [15:0] gap;
        logic [31:0] exp_status;
    } vec_t;

    // each row: opening write, commit write, clocks to wait, expected status word
    localparam int NVEC = 13;
    localparam vec_t VECS [NVEC] = '{
        '{32'h00BE0000, 32'h8CDC0010, 16'd4,    32'h8000000C}, // R2 R5 R7
        '{32'h00BE0000, 32'h80DC0010, 16'd8,    32'h80010008}, // R8 half
        '{32'h00BE0000, 32'h84DC0010, 16'd11,   32'h80000005}, // R8 quarter, not yet
        '{32'h00BE0000, 32'h88DC0020, 16'd28,   32'h80010004}, // R8 eighth
        '{32'h00BE0000, 32'h8CDC0005, 16'd5,    32'h80030000}, // R9 expiry
        '{32'h00BE0000, 32'h8CDC0005, 16'd9,    32'h80030000}, // R9 holds at zero
        '{32'h00BD0000, 32'h8CDC0010, 16'd2,    32'h80030000}, // R3 wrong opening key
        '{32'h00BE0000, 32'h8CBE0030, 16'd2,    32'h80030000}, // R3 wrong commit key
        '{32'h00BE0000, 32'h00DC0000, 16'd3,    32'h00000000}, // R4 stop
        '{32'h00BE0000, 32'h00DC0040, 16'd10,   32'h00000040}, // R7 hold while disabled
        '{32'h00BE0000, 32'h8DDC0010, 16'd192,  32'h8000000D}, // R6 divide by 64
        '{32'h00BE0000, 32'h82DC0002, 16'd4096, 32'h80010001}, // R6 divide by 4096
        '{32'h00BE0000, 32'h8FDC0003, 16'd1000, 32'h80000003}  // R6 divide by 262144
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        prewarn_o, expired_o, reset_req_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    guard_wdt dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_addr    (bus_addr),
        .bus_we      (bus_we),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .prewarn_o   (prewarn_o),
        .expired_o   (expired_o),
        .reset_req_o (reset_req_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        // R1 reset state
        rd(4'h8, v);  check("R1 status after reset", v, 32'h0);
        rd(4'h0, v);  check("R1 control after reset", v, 32'h0);
        check("R1 flags after reset", {29'b0, prewarn_o, expired_o, reset_req_o}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            wr(4'h0, VECS[i].open_word);
            wr(4'h0, VECS[i].cfg_word);
            repeat (int'(VECS[i].gap)) @(negedge clk);
            rd(4'h8, v);
            check($sformatf("R7/R8/R9 vector %0d status", i), v, VECS[i].exp_status);
            if (i == 0) begin
                rd(4'h0, v);
                check("R11 control readback", v, 32'h8C000010);
            end
            if (i == 4) check("R9 expired pin", {31'b0, expired_o}, 32'h1);
            if (i == 1) check("R8 prewarn pin", {31'b0, prewarn_o}, 32'h1);
        end

        // R9 pulse timing: reload 3 at divide-by-1 expires on the third edge
        wr(4'h0, 32'h00BE0000);
        wr(4'h0, 32'h8CDC0003);
        check("R5 flags cleared by commit", {30'b0, prewarn_o, expired_o}, 32'h0);
        repeat (2) @(negedge clk);
        check("R9 no request before expiry", {31'b0, reset_req_o}, 32'h0);
        @(negedge clk);
        check("R9 request at expiry", {31'b0, reset_req_o}, 32'h1);
        @(negedge clk);
        check("R9 request one cycle", {31'b0, reset_req_o}, 32'h0);

        // R10 status write ignored
        wr(4'h8, 32'hFFFFFFFF);
        rd(4'h8, v);  check("R10 status write ignored", v, 32'h80030000);
        rd(4'h0, v);  check("R10 control unchanged", v, 32'h8C000003);

        // R3 handshake broken by a write elsewhere
        wr(4'h0, 32'h00BE0000);
        wr(4'h8, 32'h00000000);
        wr(4'h0, 32'h80DC0020);
        rd(4'h0, v);  check("R3 interrupted handshake", v, 32'h8C000003);

        // R4 stop with all-zero settings
        wr(4'h0, 32'h00BE0000);
        wr(4'h0, 32'h00DC0000);
        rd(4'h8, v);  check("R4 status after stop", v, 32'h0);
        rd(4'h0, v);  check("R4 control after stop", v, 32'h0);

        // R1 reset while running
        wr(4'h0, 32'h00BE0000);
        wr(4'h0, 32'h8CDC0100);
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rd(4'h8, v);  check("R1 status after mid-run reset", v, 32'h0);
        rd(4'h0, v);  check("R1 control after mid-run reset", v, 32'h0);
        rst_n = 1'b1;

        finish_run();
    end

endmodule